// File: doc/BRIEF.md
# CCD Horizontal Readout Sequencer

This block runs the horizontal shift register of a CCD sensor with two outputs and a pseudo-two-phase horizontal register. The register is split into a left half and a right half, and each half has its own pair of phase inputs. Each half shifts toward one output or the other depending on which system phase drives which of its gates. On a start request the block latches a readout mode and emits one line of horizontal clocks. It drives the four half-register phase controls according to that mode and tags every clocked pixel with a region code.

Each pixel takes two system clocks. The system phase H1 is high in the first clock and H2 is high in the second, and the two are never high together. When the last required pixel has been clocked, a one-clock line-done strobe tells the vertical sequencer that it may shift the next line in. While the line runs, the vertical clock requests and the fast-dump request that arrive from outside are forced low on their way to the sensor drivers. This keeps their switching noise out of the output sampling.

Top module: `hreadout_seq`

## Requirements
- R1: In idle, a high `start_i` on a clock edge starts a line and captures `mode_i`. `busy_o` is high from the next clock on. Mode codes are 0 = single output to video 1, 1 = single output to video 2, 2 = dual output, and 3 = same as code 0.
- R2: Each pixel lasts two clocks. In the first clock the outputs driven by H1 are high, and in the second clock the outputs driven by H2 are high. No half ever has both of its phases high, and all four phase outputs are low while not busy.
- R3: Single output to video 1 (codes 0 and 3): H1 drives the left phase 1 and the right phase 2, and H2 drives the left phase 2 and the right phase 1.
- R4: Single output to video 2 (code 1): H1 drives the left phase 2 and the right phase 1, and H2 drives the left phase 1 and the right phase 2.
- R5: Dual output (code 2): H1 drives both phase-1 outputs and H2 drives both phase-2 outputs.
- R6: A single-output line has 1028 pixels. Their region codes are 0 (empty) for pixels 0–7, 1 (dark) for pixels 8–19, 2 (active) for pixels 20–1023, and 1 (dark) for pixels 1024–1027.
- R7: A dual-output line has 523 pixels. Their region codes are 0 for pixels 0–7, 1 for pixels 8–19, 2 for pixels 20–521, and 3 (trailing extra) for pixel 522.
- R8: While `busy_o` is high, `v_out_o` and `fd_out_o` are zero. Otherwise they equal `v_in_i` and `fd_in_i`.
- R9: `line_done_o` is high for exactly the one clock after the second clock of the last pixel. `busy_o` is low in that clock, a start in that clock is ignored, and the block is idle in the clock after it.
- R10: `start_i` pulses and `mode_i` changes during a line have no effect on that line.
- R11: After reset the block is idle: `busy_o`, `line_done_o`, all phase outputs and `region_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-line request |
| mode_i | input | 2 | Readout mode, captured at start |
| v_in_i | input | N_VCLK | Vertical clock requests from the vertical sequencer |
| fd_in_i | input | 1 | Fast-dump request |
| busy_o | output | 1 | Horizontal readout in progress |
| line_done_o | output | 1 | One-clock strobe: vertical shift may begin |
| lh1_o | output | 1 | Left half, phase 1 gate |
| lh2_o | output | 1 | Left half, phase 2 gate |
| rh1_o | output | 1 | Right half, phase 1 gate |
| rh2_o | output | 1 | Right half, phase 2 gate |
| region_o | output | 2 | Region code of the pixel being clocked |
| v_out_o | output | N_VCLK | Gated vertical clocks to the drivers |
| fd_out_o | output | 1 | Gated fast-dump drive |

## Verification
The bench runs whole lines in every mode code: video 1, video 2, dual, and the alias code 3. It checks all four phase outputs and the region code in each clock, which tells apart a swapped half, a wrong mode alias and a region boundary that is off by one. The single and dual lengths (1028 against 523) separate the two pixel schedules and the position of the done strobe. One line is run with start pulses and mode changes injected halfway through, and a start held high during the done clock shows that both are ignored. The vertical inputs are held active throughout, so the bench can see where the gating starts and stops.

// File: rtl/hro_pkg.sv
package hro_pkg;
  typedef enum logic [1:0] {
    MODE_VID1  = 2'd0,
    MODE_VID2  = 2'd1,
    MODE_DUAL  = 2'd2,
    MODE_VID1B = 2'd3
  } hro_mode_e;

  typedef enum logic [1:0] {
    REG_EMPTY = 2'd0,
    REG_DARK  = 2'd1,
    REG_ACT   = 2'd2,
    REG_EXTRA = 2'd3
  } hro_region_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } hro_state_e;
endpackage

// File: rtl/hro_ctrl.sv
module hro_ctrl
  import hro_pkg::*;
#(
  parameter int SGL_CYC  = 1028,
  parameter int DUAL_CYC = 523,
  parameter int CNT_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  output hro_mode_e        mode_q_o,
  output logic             run_o,
  output logic             done_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST_SGL  = CNT_W'(SGL_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_DUAL = CNT_W'(DUAL_CYC - 1);

  hro_state_e       st_q, st_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  hro_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] last;

  assign last = (mode_q == MODE_DUAL) ? LAST_DUAL : LAST_SGL;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_RUN;
          ph_d   = 1'b0;
          cnt_d  = '0;
          mode_d = hro_mode_e'(mode_i);
        end
      end
      ST_RUN: begin
        if (!ph_q) begin
          ph_d = 1'b1;
        end else if (cnt_q == last) begin
          st_d = ST_DONE;
          ph_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
          ph_d  = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      mode_q <= MODE_VID1;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign mode_q_o = mode_q;
  assign run_o    = (st_q == ST_RUN);
  assign done_o   = (st_q == ST_DONE);
  assign h1_o     = run_o && !ph_q;
  assign h2_o     = run_o && ph_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/hro_phase_map.sv
module hro_phase_map
  import hro_pkg::*;
(
  input  hro_mode_e  mode_i,
  input  logic       h1_i,
  input  logic       h2_i,
  output logic [1:0] ph1_o,
  output logic [1:0] ph2_o
);
  // Index 0 is the left half, index 1 the right half.
  // fwd[h]: the half's phase 1 follows H1 (shift toward its own side).
  logic [1:0] fwd;

  always_comb begin
    unique case (mode_i)
      MODE_VID2: fwd = 2'b10;
      MODE_DUAL: fwd = 2'b11;
      default:   fwd = 2'b01;
    endcase
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign ph1_o[h] = fwd[h] ? h1_i : h2_i;
    assign ph2_o[h] = fwd[h] ? h2_i : h1_i;
  end
endmodule

// File: rtl/hro_region.sv
module hro_region
  import hro_pkg::*;
#(
  parameter int N_EMPTY    = 8,
  parameter int N_DARK     = 12,
  parameter int N_ACT_SGL  = 1004,
  parameter int N_ACT_DUAL = 502,
  parameter int CNT_W      = 11
) (
  input  logic             run_i,
  input  logic             dual_i,
  input  logic [CNT_W-1:0] cnt_i,
  output hro_region_e      region_o
);
  localparam logic [CNT_W-1:0] B_EMPTY = CNT_W'(N_EMPTY);
  localparam logic [CNT_W-1:0] B_DARK  = CNT_W'(N_EMPTY + N_DARK);
  localparam logic [CNT_W-1:0] B_ACT_S = CNT_W'(N_EMPTY + N_DARK + N_ACT_SGL);
  localparam logic [CNT_W-1:0] B_ACT_D = CNT_W'(N_EMPTY + N_DARK + N_ACT_DUAL);

  always_comb begin
    if (!run_i)                       region_o = REG_EMPTY;
    else if (cnt_i < B_EMPTY)         region_o = REG_EMPTY;
    else if (cnt_i < B_DARK)          region_o = REG_DARK;
    else if (dual_i)                  region_o = (cnt_i < B_ACT_D) ? REG_ACT : REG_EXTRA;
    else                              region_o = (cnt_i < B_ACT_S) ? REG_ACT : REG_DARK;
  end
endmodule

// File: rtl/hreadout_seq.sv
module hreadout_seq
  import hro_pkg::*;
#(
  parameter int N_EMPTY    = 8,
  parameter int N_DARK     = 12,
  parameter int N_ACT_SGL  = 1004,
  parameter int N_TAIL_SGL = 4,
  parameter int N_ACT_DUAL = 502,
  parameter int N_VCLK     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [N_VCLK-1:0] v_in_i,
  input  logic              fd_in_i,
  output logic              busy_o,
  output logic              line_done_o,
  output logic              lh1_o,
  output logic              lh2_o,
  output logic              rh1_o,
  output logic              rh2_o,
  output logic [1:0]        region_o,
  output logic [N_VCLK-1:0] v_out_o,
  output logic              fd_out_o
);
  localparam int SGL_CYC  = N_EMPTY + N_DARK + N_ACT_SGL + N_TAIL_SGL;
  localparam int DUAL_CYC = N_EMPTY + N_DARK + N_ACT_DUAL + 1;
  localparam int MAX_CYC  = (SGL_CYC > DUAL_CYC) ? SGL_CYC : DUAL_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC);

  logic rst_s1, rst_sn;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  hro_mode_e        mode_q;
  logic             run, done, h1, h2;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       ph1, ph2;
  hro_region_e      region;

  hro_ctrl #(.SGL_CYC(SGL_CYC), .DUAL_CYC(DUAL_CYC), .CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_sn), .start_i(start_i), .mode_i(mode_i),
    .mode_q_o(mode_q), .run_o(run), .done_o(done), .h1_o(h1), .h2_o(h2), .cnt_o(cnt)
  );

  hro_phase_map u_map (
    .mode_i(mode_q), .h1_i(h1), .h2_i(h2), .ph1_o(ph1), .ph2_o(ph2)
  );

  hro_region #(.N_EMPTY(N_EMPTY), .N_DARK(N_DARK), .N_ACT_SGL(N_ACT_SGL),
               .N_ACT_DUAL(N_ACT_DUAL), .CNT_W(CNT_W)) u_region (
    .run_i(run), .dual_i(mode_q == MODE_DUAL), .cnt_i(cnt), .region_o(region)
  );

  assign busy_o      = run;
  assign line_done_o = done;
  assign lh1_o       = ph1[0];
  assign lh2_o       = ph2[0];
  assign rh1_o       = ph1[1];
  assign rh2_o       = ph2[1];
  assign region_o    = region;
  assign v_out_o     = run ? '0 : v_in_i;
  assign fd_out_o    = run ? 1'b0 : fd_in_i;
endmodule

// File: rtl/hro_checker.sv
module hro_checker #(
  parameter int N_VCLK = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              line_done_o,
  input logic              lh1_o,
  input logic              lh2_o,
  input logic              rh1_o,
  input logic              rh2_o,
  input logic [1:0]        mode_q,
  input logic [N_VCLK-1:0] v_out_o,
  input logic              fd_out_o,
  input logic              h1,
  input logic              h2
);
  a_r2_half_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lh1_o && lh2_o) && !(rh1_o && rh2_o));

  a_r2_h1_then_h2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h1 |=> h2);

  a_r5_dual_halves_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q == 2'd2) |-> (lh1_o == rh1_o) && (lh2_o == rh2_o));

  a_r8_vert_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (v_out_o == '0) && !fd_out_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !line_done_o && !busy_o);

  a_r9_done_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_done_o) |-> $past(busy_o));

  a_r1_start_begins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind hreadout_seq hro_checker #(.N_VCLK(N_VCLK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .line_done_o(line_done_o), .lh1_o(lh1_o), .lh2_o(lh2_o), .rh1_o(rh1_o),
  .rh2_o(rh2_o), .mode_q(mode_q), .v_out_o(v_out_o), .fd_out_o(fd_out_o),
  .h1(h1), .h2(h2)
);

// File: tb/hreadout_seq_tb.sv
`timescale 1ns/1ps
module hreadout_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [1:0] mode_i;
  logic [2:0] v_in_i;
  logic       fd_in_i;
  logic       busy_o, line_done_o, lh1_o, lh2_o, rh1_o, rh2_o, fd_out_o;
  logic [1:0] region_o;
  logic [2:0] v_out_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  hreadout_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .v_in_i(v_in_i), .fd_in_i(fd_in_i), .busy_o(busy_o), .line_done_o(line_done_o),
    .lh1_o(lh1_o), .lh2_o(lh2_o), .rh1_o(rh1_o), .rh2_o(rh2_o),
    .region_o(region_o), .v_out_o(v_out_o), .fd_out_o(fd_out_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected {lh1,lh2,rh1,rh2} from the mode tables of R3, R4, R5.
  function automatic logic [3:0] exp_gates(input logic [1:0] m, input bit first);
    logic [3:0] a;
    case (m)
      2'd1:    a = 4'b0110;
      2'd2:    a = 4'b1010;
      default: a = 4'b1001;
    endcase
    if (m == 2'd2) return first ? a : 4'b0101;
    return first ? a : ~a;
  endfunction

  // Region schedules of R6 (single) and R7 (dual).
  function automatic int exp_region(input logic [1:0] m, input int p);
    if (p < 8)  return 0;
    if (p < 20) return 1;
    if (m == 2'd2) return (p < 522) ? 2 : 3;
    return (p < 1024) ? 2 : 1;
  endfunction

  task automatic run_line(input logic [1:0] m, input bit disturb);
    int n = (m == 2'd2) ? 523 : 1028;
    int e_busy = 0, e_gate = 0, e_reg = 0, e_vert = 0;
    string tag = (m == 2'd2) ? "R7" : "R6";
    string mtag = (m == 2'd1) ? "R4" : (m == 2'd2) ? "R5" : "R3";
    mode_i  = m;
    start_i = 1'b1;
    v_in_i  = 3'b101;
    fd_in_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int p = 0; p < n; p++) begin
      for (int k = 0; k < 2; k++) begin
        if (disturb && p == 50 && k == 0) begin start_i = 1'b1; mode_i = m ^ 2'd1; end
        if (disturb && p == 51 && k == 0) begin start_i = 1'b0; mode_i = 2'd2; end
        if (busy_o !== 1'b1 || line_done_o !== 1'b0) e_busy++;
        if ({lh1_o, lh2_o, rh1_o, rh2_o} !== exp_gates(m, k == 0)) e_gate++;
        if (int'(region_o) != exp_region(m, p)) e_reg++;
        if (v_out_o !== 3'b000 || fd_out_o !== 1'b0) e_vert++;
        @(negedge clk_i);
      end
    end
    chk({"R1 busy mismatches during line"}, e_busy, 0);
    chk({mtag, " phase gate mismatches"}, e_gate, 0);
    chk({tag, " region mismatches"}, e_reg, 0);
    chk("R8 vertical/fast-dump not low while busy", e_vert, 0);
    if (disturb) chk("R10 mid-line start/mode disturbed line", e_busy + e_gate + e_reg, 0);
    // Done clock
    chk({tag, " R9 line_done after last pixel"}, line_done_o, 1);
    chk("R9 busy low during done", busy_o, 0);
    chk("R2 gates low during done", {lh1_o, lh2_o, rh1_o, rh2_o}, 0);
    chk("R8 vertical passes when not busy", {v_out_o, fd_out_o}, 4'b1011);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R9 done lasts one clock", line_done_o, 0);
    chk("R9 start in done clock ignored", busy_o, 0);
    @(negedge clk_i);
  endtask

  initial begin
    rst_ni  = 1'b0;
    start_i = 1'b0;
    mode_i  = 2'd0;
    v_in_i  = 3'b011;
    fd_in_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R11 busy in reset", busy_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R11 busy after reset", busy_o, 0);
    chk("R11 done after reset", line_done_o, 0);
    chk("R11 gates after reset", {lh1_o, lh2_o, rh1_o, rh2_o}, 0);
    chk("R11 region after reset", region_o, 0);
    chk("R8 vertical passes in idle", {v_out_o, fd_out_o}, 4'b0110);

    run_line(2'd0, 1'b0);
    run_line(2'd1, 1'b0);
    run_line(2'd2, 1'b1);
    run_line(2'd3, 1'b0);
    run_line(2'd2, 1'b0);

    repeat (3) @(negedge clk_i);
    chk("R1 stays idle without start", busy_o, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule